// File: doc/BRIEF.md
# Strict-Priority Dual-FIFO Stream Merger

This block joins two streaming sources, one urgent and one background, onto a single streaming output. Each source writes into its own synchronous FIFO. Because the sources do not compete for a shared buffer, a collision between them never loses a beat: each one is simply held in its own queue until the output can take it.

The output picks its source one beat at a time. It always prefers the urgent queue and takes a background beat only when the urgent queue holds nothing. There is no fairness scheme, so steady urgent traffic can hold off the background source for as long as it continues. The end-of-packet marker is stored with each beat and leaves the block on that same beat. Because the choice is made per beat, an urgent beat can land between two beats of one background packet.

Top module: `prio_merge`

## Requirements
- R1: In a cycle where the synchronous active-low reset is low, both FIFOs are cleared. After the reset edge, `m_valid` is 0 and both `hp_ready` and `lp_ready` are 1.
- R2: An input beat is written when its valid and ready are both high. Its ready is high when its FIFO has a free entry. It is also high when the FIFO is full and a beat from that FIFO leaves on the output in the same cycle.
- R3: Every accepted beat leaves on the output exactly once, and the beats of each input leave in the order they arrived. No FIFO overflows or underflows.
- R4: When the output presents a new beat (it is not still holding a stalled one), it takes it from the high-priority FIFO whenever that FIFO is not empty. It takes a low-priority beat only when the high-priority FIFO is empty.
- R5: The last flag of each beat appears on the output together with that beat's data.
- R6: While `m_valid` is 1 and `m_ready` is 0, the next cycle keeps `m_valid` at 1 with unchanged `m_data` and `m_last`, even if a high-priority beat arrives. A FIFO entry is removed only on an output handshake.
- R7: `m_valid` is 1 exactly when at least one FIFO holds a beat. A beat accepted at a clock edge can be presented on the output in the cycle after that edge.
- R8: The source is chosen per beat. A high-priority beat accepted while a low-priority packet is partly sent goes out before the remaining beats of that packet.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hp_data | input | DATA_W | High-priority beat data |
| hp_valid | input | 1 | High-priority beat valid |
| hp_last | input | 1 | High-priority end of packet |
| hp_ready | output | 1 | High-priority input can accept |
| lp_data | input | DATA_W | Low-priority beat data |
| lp_valid | input | 1 | Low-priority beat valid |
| lp_last | input | 1 | Low-priority end of packet |
| lp_ready | output | 1 | Low-priority input can accept |
| m_data | output | DATA_W | Merged output data |
| m_valid | output | 1 | Merged output valid |
| m_last | output | 1 | Merged output end of packet |
| m_ready | input | 1 | Downstream can accept |

## Verification
The assertions assume that the upstream sources follow the handshake rule, so a beat counts only when both valid and ready are high. The stall and priority properties also assume that `m_ready` is a clean level at each clock edge. The bench drivers keep each input beat asserted until its ready has been seen high. They change inputs and `m_ready` only just after a rising edge, and a single process drives each input. The stimulus fills a FIFO to full with the output blocked, pushes a write into a full FIFO in the same cycle as a pop, and stalls a low-priority beat while a high-priority beat arrives. It also randomizes `m_ready` under traffic on both inputs, so that every case the assertions depend on actually occurs.

// File: rtl/prio_merge_pkg.sv
package prio_merge_pkg;
   typedef enum logic {
      SRC_HP = 1'b0,
      SRC_LP = 1'b1
   } src_e;

   localparam int unsigned N_LANES = 2;
endpackage

// File: rtl/pm_fifo.sv
module pm_fifo #(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned WIDTH = 33
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [WIDTH-1:0] wr_data,
   input  logic             rd_en,
   output logic [WIDTH-1:0] rd_data,
   output logic             empty,
   output logic             full
);
   localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned CNT_W = $clog2(DEPTH + 1);
   localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

   if (DEPTH < 2) begin : g_bad_depth
      $error("pm_fifo: DEPTH must be at least 2");
   end
   if (WIDTH < 2) begin : g_bad_width
      $error("pm_fifo: WIDTH must be at least 2");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr;
   logic [CNT_W-1:0] count;

   assign empty   = (count == '0);
   assign full    = (count == FULL_CNT);
   assign rd_data = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (wr_en) begin
         mem[wr_ptr] <= wr_data;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (wr_en) begin
            wr_ptr <= (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
         end
         if (rd_en) begin
            rd_ptr <= (rd_ptr == LAST_IDX) ? '0 : rd_ptr + 1'b1;
         end
         case ({wr_en, rd_en})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && full) |-> rd_en); // R3
   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |-> !empty); // R3
   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !rd_en) |=> !empty); // R3
endmodule

// File: rtl/pm_select.sv
module pm_select
   import prio_merge_pkg::*;
#(
   parameter int unsigned WIDTH = 33
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hp_empty,
   input  logic             lp_empty,
   input  logic [WIDTH-1:0] hp_head,
   input  logic [WIDTH-1:0] lp_head,
   input  logic             out_ready,
   output logic             out_valid,
   output logic [WIDTH-1:0] out_beat,
   output logic             hp_pop,
   output logic             lp_pop
);
   logic held_q;
   src_e held_src_q;
   src_e cur_src;

   always_comb begin
      if (held_q) begin
         cur_src = held_src_q;
      end else if (!hp_empty) begin
         cur_src = SRC_HP;
      end else begin
         cur_src = SRC_LP;
      end
   end

   assign out_valid = held_q || !hp_empty || !lp_empty;
   assign out_beat  = (cur_src == SRC_HP) ? hp_head : lp_head;
   assign hp_pop    = out_valid && out_ready && (cur_src == SRC_HP);
   assign lp_pop    = out_valid && out_ready && (cur_src == SRC_LP);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held_q     <= 1'b0;
         held_src_q <= SRC_HP;
      end else begin
         held_q     <= out_valid && !out_ready;
         held_src_q <= cur_src;
      end
   end

   AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_beat))); // R6
   AST_HP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      lp_pop |-> (hp_empty || $past(out_valid && !out_ready))); // R4
   AST_ONE_POP: assert property (@(posedge clk) disable iff (!rst_n)
      !(hp_pop && lp_pop)); // R3
endmodule

// File: rtl/prio_merge.sv
module prio_merge
   import prio_merge_pkg::*;
#(
   parameter int unsigned DEPTH  = 16,
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] hp_data,
   input  logic              hp_valid,
   input  logic              hp_last,
   output logic              hp_ready,
   input  logic [DATA_W-1:0] lp_data,
   input  logic              lp_valid,
   input  logic              lp_last,
   output logic              lp_ready,
   output logic [DATA_W-1:0] m_data,
   output logic              m_valid,
   output logic              m_last,
   input  logic              m_ready
);
   localparam int unsigned BEAT_W = DATA_W + 1;

   if (DATA_W < 1) begin : g_bad_data_w
      $error("prio_merge: DATA_W must be at least 1");
   end

   logic [BEAT_W-1:0] lane_in   [N_LANES];
   logic [BEAT_W-1:0] lane_head [N_LANES];
   logic              lane_valid [N_LANES];
   logic              lane_ready [N_LANES];
   logic              lane_empty [N_LANES];
   logic              lane_full  [N_LANES];
   logic              lane_pop   [N_LANES];
   logic [BEAT_W-1:0] out_beat;

   assign lane_in[SRC_HP]    = {hp_last, hp_data};
   assign lane_in[SRC_LP]    = {lp_last, lp_data};
   assign lane_valid[SRC_HP] = hp_valid;
   assign lane_valid[SRC_LP] = lp_valid;
   assign hp_ready           = lane_ready[SRC_HP];
   assign lp_ready           = lane_ready[SRC_LP];

   for (genvar i = 0; i < N_LANES; i++) begin : g_lane
      assign lane_ready[i] = !lane_full[i] || lane_pop[i];

      pm_fifo #(
         .DEPTH (DEPTH),
         .WIDTH (BEAT_W)
      ) u_fifo (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (lane_valid[i] && lane_ready[i]),
         .wr_data (lane_in[i]),
         .rd_en   (lane_pop[i]),
         .rd_data (lane_head[i]),
         .empty   (lane_empty[i]),
         .full    (lane_full[i])
      );
   end

   pm_select #(
      .WIDTH (BEAT_W)
   ) u_select (
      .clk       (clk),
      .rst_n     (rst_n),
      .hp_empty  (lane_empty[SRC_HP]),
      .lp_empty  (lane_empty[SRC_LP]),
      .hp_head   (lane_head[SRC_HP]),
      .lp_head   (lane_head[SRC_LP]),
      .out_ready (m_ready),
      .out_valid (m_valid),
      .out_beat  (out_beat),
      .hp_pop    (lane_pop[SRC_HP]),
      .lp_pop    (lane_pop[SRC_LP])
   );

   assign m_data = out_beat[DATA_W-1:0];
   assign m_last = out_beat[DATA_W];

   AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (lane_full[SRC_HP] && !m_ready) |-> !hp_ready); // R2
   AST_VALID_WHEN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (hp_valid && hp_ready) |=> m_valid); // R7
endmodule

// File: tb/prio_merge_tb.sv
module prio_merge_tb;
   localparam int DEPTH  = 4;
   localparam int DATA_W = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [DATA_W-1:0] hp_data = '0, lp_data = '0;
   logic hp_valid = 1'b0, hp_last = 1'b0, lp_valid = 1'b0, lp_last = 1'b0;
   logic hp_ready, lp_ready;
   logic [DATA_W-1:0] m_data;
   logic m_valid, m_last;
   logic m_ready = 1'b0;
   logic rand_rdy = 1'b0;
   logic rdy_force = 1'b0;

   int total = 0;
   int bad = 0;
   string phase = "R3";

   always #2.5 clk = ~clk;

   prio_merge #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .hp_data(hp_data), .hp_valid(hp_valid), .hp_last(hp_last), .hp_ready(hp_ready),
      .lp_data(lp_data), .lp_valid(lp_valid), .lp_last(lp_last), .lp_ready(lp_ready),
      .m_data(m_data), .m_valid(m_valid), .m_last(m_last), .m_ready(m_ready)
   );

   always @(posedge clk) begin
      #1;
      m_ready = rand_rdy ? (($urandom & 1) != 0) : rdy_force;
   end

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   // scoreboard queues: beats held inside each FIFO, as {last, data}
   logic [DATA_W:0] hp_q[$];
   logic [DATA_W:0] lp_q[$];
   logic [DATA_W:0] pend_hp, pend_lp;
   bit pend_hp_v = 0, pend_lp_v = 0;
   bit held = 0;
   bit held_src = 0;

   always @(negedge clk) begin
      if (!rst_n) begin
         hp_q.delete(); lp_q.delete();
         pend_hp_v = 0; pend_lp_v = 0; held = 0;
      end else begin
         bit src;
         bit pop_hp, pop_lp;
         logic [DATA_W:0] exp_beat;
         if (pend_hp_v) hp_q.push_back(pend_hp);
         if (pend_lp_v) lp_q.push_back(pend_lp);
         pop_hp = 0; pop_lp = 0;
         // R7: valid exactly when something is buffered
         check("R7 valid", 64'(m_valid), 64'((hp_q.size() + lp_q.size()) != 0));
         if (m_valid) begin
            if (held) src = held_src;         // R6 hold
            else src = (hp_q.size() != 0) ? 1'b0 : 1'b1; // R4 priority
            if (src == 1'b0 && hp_q.size() != 0) exp_beat = hp_q[0];
            else if (src == 1'b1 && lp_q.size() != 0) exp_beat = lp_q[0];
            else exp_beat = 'x;
            // R5 last travels with data
            check({phase, " R5 beat"}, 64'({m_last, m_data}), 64'(exp_beat));
            if (m_ready) begin
               if (src == 1'b0) pop_hp = 1; else pop_lp = 1;
            end
            held = !m_ready;
            held_src = src;
         end else begin
            held = 0;
         end
         // R2 ready rule
         check("R2 hp_ready", 64'(hp_ready), 64'((hp_q.size() < DEPTH) || pop_hp));
         check("R2 lp_ready", 64'(lp_ready), 64'((lp_q.size() < DEPTH) || pop_lp));
         if (pop_hp && hp_q.size() != 0) void'(hp_q.pop_front());
         if (pop_lp && lp_q.size() != 0) void'(lp_q.pop_front());
         pend_hp_v = hp_valid && hp_ready;
         pend_hp = {hp_last, hp_data};
         pend_lp_v = lp_valid && lp_ready;
         pend_lp = {lp_last, lp_data};
      end
   end

   task automatic send_hp(input logic [DATA_W-1:0] d, input logic l);
      hp_data = d; hp_last = l; hp_valid = 1'b1;
      do @(negedge clk); while (!hp_ready);
      @(posedge clk); #1;
      hp_valid = 1'b0;
   endtask

   task automatic send_lp(input logic [DATA_W-1:0] d, input logic l);
      lp_data = d; lp_last = l; lp_valid = 1'b1;
      do @(negedge clk); while (!lp_ready);
      @(posedge clk); #1;
      lp_valid = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   initial begin
      #400000;
      bad++; total++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      idle(4);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check("R1 m_valid", 64'(m_valid), 64'd0);
      check("R1 hp_ready", 64'(hp_ready), 64'd1);
      check("R1 lp_ready", 64'(lp_ready), 64'd1);
      idle(1);

      // R3 R5: low-priority packet alone
      phase = "R3"; rdy_force = 1'b1;
      for (int i = 0; i < 3; i++) send_lp(32'h1000 + i, i == 2);
      idle(4);
      // R3: high-priority alone
      for (int i = 0; i < 3; i++) send_hp(32'h2000 + i, i == 2);
      idle(4);

      // R4: both queued while blocked, HP drains first
      phase = "R4"; rdy_force = 1'b0;
      fork
         for (int i = 0; i < 3; i++) send_hp(32'h3000 + i, i == 2);
         for (int i = 0; i < 3; i++) send_lp(32'h3100 + i, i == 2);
      join
      idle(2);
      rdy_force = 1'b1;
      idle(10);

      // R2: fill HP FIFO, then write while full and popping
      phase = "R2"; rdy_force = 1'b0;
      for (int i = 0; i < DEPTH; i++) send_hp(32'h4000 + i, 1'b0);
      @(negedge clk);
      check("R2 full blocks", 64'(hp_ready), 64'd0);
      idle(1);
      fork
         send_hp(32'h40ff, 1'b1);
         begin idle(2); rdy_force = 1'b1; end
      join
      idle(10);

      // R6: LP beat stalled while HP arrives
      phase = "R6"; rdy_force = 1'b0;
      send_lp(32'h5000, 1'b1);
      idle(2);
      send_hp(32'h5100, 1'b1);
      idle(3);
      rdy_force = 1'b1;
      idle(6);

      // R8: HP beat cuts into an LP packet
      phase = "R8";
      fork
         for (int i = 0; i < 6; i++) send_lp(32'h6000 + i, i == 5);
         begin idle(3); send_hp(32'h6100, 1'b1); end
      join
      idle(6);

      // R3 R4: random traffic with random backpressure
      phase = "R4"; rand_rdy = 1'b1;
      fork
         for (int i = 0; i < 40; i++) begin
            send_hp(32'h7000 + i, (i % 5) == 4);
            idle($urandom_range(0, 3));
         end
         for (int i = 0; i < 40; i++) begin
            send_lp(32'h8000 + i, (i % 4) == 3);
            idle($urandom_range(0, 2));
         end
      join
      rand_rdy = 1'b0; rdy_force = 1'b1;
      idle(30);
      // R3: everything accepted has left
      check("R3 drained", 64'(hp_q.size() + lp_q.size()), 64'd0);
      check("R3 idle valid", 64'(m_valid), 64'd0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule